// File: doc/BRIEF.md
# Coherence Population Counter Monitor

This block follows a single memory line held by `N` caches that use an invalidation protocol with four line states: invalid, exclusive, shared and dirty. It does not keep a state for each cache. Instead it keeps four population counters, one per state, and updates them through guarded transitions. Each accepted event is one of five kinds: read hit, read miss, write hit, write miss or replacement. A replacement also carries a code that names the state of the evicted copy.

At each clock edge the block takes at most one event. If the event's guard holds, the counters move to their new values. If the guard fails, the counters stay where they are and a one-cycle illegal-event pulse is raised. A sticky error flag records two kinds of fault: an incoherent population (two or more dirty copies, or a dirty copy alongside a shared one) and a set of counters that no longer sums to `N`. Only reset clears this flag.

Top module: `coh_pop_monitor`

## Requirements
- R1: After reset the invalid count equals N, the exclusive, shared and dirty counts are zero, and both `illegal_o` and `unsafe_o` are low.
- R2: A read hit (event code 0) is legal only when at least one copy is dirty, shared or exclusive. It leaves all four counters unchanged.
- R3: A read miss (event code 1) needs at least one invalid cache. When no valid copy exists, one cache moves from invalid to exclusive.
- R4: A read miss with at least one dirty copy takes one from invalid and one from dirty and adds two to shared. This case wins over R5.
- R5: A read miss with no dirty copy but some shared or exclusive copy takes one from invalid, sets shared to shared+exclusive+1, and sets exclusive to zero.
- R6: A write hit (event code 2) checks states in priority order. If any copy is dirty, nothing changes. Otherwise, if any copy is exclusive, one moves from exclusive to dirty.
- R7: A write hit with only shared copies sets dirty to dirty+1, adds shared-1 to invalid, and clears shared.
- R8: A write miss (event code 3) needs at least one invalid cache. Afterwards dirty is 1, exclusive and shared are 0, and invalid holds all the remaining caches.
- R9: A replacement (event code 4) uses `victim_i`, where 0 means dirty, 1 means shared and 2 means exclusive. It needs the named counter to be at least 1, takes one from it and adds one to invalid. Victim code 3 is illegal.
- R10: An event whose guard fails leaves every counter unchanged. The same applies to event codes 5 to 7. In each case `illegal_o` is high for exactly the cycle after the edge that took the event. With `ev_valid_i` low, nothing changes and `illegal_o` is low.
- R11: `unsafe_o` is sticky. It rises once dirty is 2 or more, or once dirty and shared are both at least 1. It never rises under any sequence of legal or illegal events.
- R12: The four counters always sum to N. A mismatch would also set the sticky `unsafe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_valid_i | input | 1 | An event is presented this cycle |
| ev_type_i | input | 3 | Event code (0 read hit, 1 read miss, 2 write hit, 3 write miss, 4 replacement) |
| victim_i | input | 2 | Replacement victim state (0 dirty, 1 shared, 2 exclusive) |
| inv_cnt_o | output | $clog2(N+1) | Invalid population |
| exc_cnt_o | output | $clog2(N+1) | Exclusive population |
| shr_cnt_o | output | $clog2(N+1) | Shared population |
| dty_cnt_o | output | $clog2(N+1) | Dirty population |
| illegal_o | output | 1 | One-cycle pulse for a rejected event |
| unsafe_o | output | 1 | Sticky incoherence or population-sum error |

## Verification
The assertions assume that the counters can change only through events the block decodes itself. Under that assumption, the conservation of the sum and the absence of incoherent populations are properties of the transition rules, whatever events arrive. The stimulus drives only the declared ports and changes them at the falling edge. It mixes directed sequences that reach every guard boundary, such as draining invalid to zero and replacing absent victims, with a random stream that includes reserved event and victim codes. Every reachable population therefore comes from legal transitions, which is the only condition the checker relies on.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [2:0] {
    EV_RD_HIT  = 3'd0,
    EV_RD_MISS = 3'd1,
    EV_WR_HIT  = 3'd2,
    EV_WR_MISS = 3'd3,
    EV_REPL    = 3'd4
  } ev_e;

  typedef enum logic [1:0] {
    VIC_DTY = 2'd0,
    VIC_SHR = 2'd1,
    VIC_EXC = 2'd2
  } vic_e;

  typedef struct packed {
    logic rd_hit;
    logic rd_miss;
    logic wr_hit;
    logic wr_miss;
    logic repl;
    logic bad;
  } ev_dec_t;
endpackage

// File: rtl/coh_evt_decode.sv
module coh_evt_decode
  import coh_pkg::*;
(
  input  logic          valid_i,
  input  logic [2:0]    type_i,
  output ev_dec_t       dec_o
);
  always_comb begin
    dec_o = '0;
    if (valid_i) begin
      unique case (type_i)
        EV_RD_HIT:  dec_o.rd_hit  = 1'b1;
        EV_RD_MISS: dec_o.rd_miss = 1'b1;
        EV_WR_HIT:  dec_o.wr_hit  = 1'b1;
        EV_WR_MISS: dec_o.wr_miss = 1'b1;
        EV_REPL:    dec_o.repl    = 1'b1;
        default:    dec_o.bad     = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/coh_next_state.sv
module coh_next_state
  import coh_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = $clog2(N + 1)
) (
  input  ev_dec_t         dec_i,
  input  logic [1:0]      victim_i,
  input  logic [CW-1:0]   inv_i,
  input  logic [CW-1:0]   exc_i,
  input  logic [CW-1:0]   shr_i,
  input  logic [CW-1:0]   dty_i,
  output logic [CW-1:0]   inv_o,
  output logic [CW-1:0]   exc_o,
  output logic [CW-1:0]   shr_o,
  output logic [CW-1:0]   dty_o,
  output logic            reject_o
);
  localparam int SW = CW + 2;

  logic [SW-1:0] i_w, e_w, s_w, d_w;
  logic [SW-1:0] i_n, e_n, s_n, d_n;
  logic          have_inv, have_exc, have_shr, have_dty, have_valid;

  assign i_w = SW'(inv_i);
  assign e_w = SW'(exc_i);
  assign s_w = SW'(shr_i);
  assign d_w = SW'(dty_i);

  assign have_inv   = inv_i != '0;
  assign have_exc   = exc_i != '0;
  assign have_shr   = shr_i != '0;
  assign have_dty   = dty_i != '0;
  assign have_valid = have_exc | have_shr | have_dty;

  always_comb begin
    i_n      = i_w;
    e_n      = e_w;
    s_n      = s_w;
    d_n      = d_w;
    reject_o = 1'b0;
    if (dec_i.bad) begin
      reject_o = 1'b1;
    end else if (dec_i.rd_hit) begin
      reject_o = !have_valid;
    end else if (dec_i.rd_miss) begin
      if (!have_inv) begin
        reject_o = 1'b1;
      end else if (!have_valid) begin
        i_n = i_w - 1'b1;
        e_n = e_w + 1'b1;
      end else if (have_dty) begin
        // dirty owner supplies data and degrades to shared
        i_n = i_w - 1'b1;
        d_n = d_w - 1'b1;
        s_n = s_w + SW'(2);
      end else begin
        i_n = i_w - 1'b1;
        s_n = s_w + e_w + 1'b1;
        e_n = '0;
      end
    end else if (dec_i.wr_hit) begin
      if (have_dty) begin
        reject_o = 1'b0;
      end else if (have_exc) begin
        e_n = e_w - 1'b1;
        d_n = d_w + 1'b1;
      end else if (have_shr) begin
        i_n = i_w + s_w - 1'b1;
        s_n = '0;
        d_n = d_w + 1'b1;
      end else begin
        reject_o = 1'b1;
      end
    end else if (dec_i.wr_miss) begin
      if (!have_inv) begin
        reject_o = 1'b1;
      end else begin
        i_n = i_w + e_w + s_w + d_w - 1'b1;
        e_n = '0;
        s_n = '0;
        d_n = SW'(1);
      end
    end else if (dec_i.repl) begin
      unique case (victim_i)
        VIC_DTY: begin
          reject_o = !have_dty;
          if (have_dty) begin
            d_n = d_w - 1'b1;
            i_n = i_w + 1'b1;
          end
        end
        VIC_SHR: begin
          reject_o = !have_shr;
          if (have_shr) begin
            s_n = s_w - 1'b1;
            i_n = i_w + 1'b1;
          end
        end
        VIC_EXC: begin
          reject_o = !have_exc;
          if (have_exc) begin
            e_n = e_w - 1'b1;
            i_n = i_w + 1'b1;
          end
        end
        default: reject_o = 1'b1;
      endcase
    end
  end

  assign inv_o = i_n[CW-1:0];
  assign exc_o = e_n[CW-1:0];
  assign shr_o = s_n[CW-1:0];
  assign dty_o = d_n[CW-1:0];
endmodule

// File: rtl/coh_flag_track.sv
module coh_flag_track #(
  parameter int N  = 4,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] inv_i,
  input  logic [CW-1:0] exc_i,
  input  logic [CW-1:0] shr_i,
  input  logic [CW-1:0] dty_i,
  output logic          err_o
);
  localparam int SW = CW + 2;

  logic [SW-1:0] total;
  logic          incoherent, sum_bad, err_q;

  assign total      = SW'(inv_i) + SW'(exc_i) + SW'(shr_i) + SW'(dty_i);
  assign sum_bad    = total != SW'(N);
  assign incoherent = (dty_i > CW'(1)) | ((dty_i != '0) & (shr_i != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | incoherent | sum_bad;
  end

  assign err_o = err_q;
endmodule

// File: rtl/coh_pop_monitor.sv
module coh_pop_monitor
  import coh_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ev_valid_i,
  input  logic [2:0]    ev_type_i,
  input  logic [1:0]    victim_i,
  output logic [CW-1:0] inv_cnt_o,
  output logic [CW-1:0] exc_cnt_o,
  output logic [CW-1:0] shr_cnt_o,
  output logic [CW-1:0] dty_cnt_o,
  output logic          illegal_o,
  output logic          unsafe_o
);
  ev_dec_t       dec;
  logic [CW-1:0] inv_q, exc_q, shr_q, dty_q;
  logic [CW-1:0] inv_d, exc_d, shr_d, dty_d;
  logic          reject, illegal_q;

  coh_evt_decode u_dec (
    .valid_i (ev_valid_i),
    .type_i  (ev_type_i),
    .dec_o   (dec)
  );

  coh_next_state #(.N(N), .CW(CW)) u_nxt (
    .dec_i    (dec),
    .victim_i (victim_i),
    .inv_i    (inv_q),
    .exc_i    (exc_q),
    .shr_i    (shr_q),
    .dty_i    (dty_q),
    .inv_o    (inv_d),
    .exc_o    (exc_d),
    .shr_o    (shr_d),
    .dty_o    (dty_d),
    .reject_o (reject)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_q     <= CW'(N);
      exc_q     <= '0;
      shr_q     <= '0;
      dty_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= reject;
      if (!reject) begin
        inv_q <= inv_d;
        exc_q <= exc_d;
        shr_q <= shr_d;
        dty_q <= dty_d;
      end
    end
  end

  coh_flag_track #(.N(N), .CW(CW)) u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inv_i  (inv_d),
    .exc_i  (exc_d),
    .shr_i  (shr_d),
    .dty_i  (dty_d),
    .err_o  (unsafe_o)
  );

  assign inv_cnt_o = inv_q;
  assign exc_cnt_o = exc_q;
  assign shr_cnt_o = shr_q;
  assign dty_cnt_o = dty_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/coh_pop_monitor_chk.sv
module coh_pop_monitor_chk #(
  parameter int N  = 4,
  parameter int CW = $clog2(N + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ev_valid_i,
  input logic [2:0]    ev_type_i,
  input logic [1:0]    victim_i,
  input logic [CW-1:0] inv_cnt_o,
  input logic [CW-1:0] exc_cnt_o,
  input logic [CW-1:0] shr_cnt_o,
  input logic [CW-1:0] dty_cnt_o,
  input logic          illegal_o,
  input logic          unsafe_o
);
  localparam int SW = CW + 2;
  logic [SW-1:0] total;
  assign total = SW'(inv_cnt_o) + SW'(exc_cnt_o) + SW'(shr_cnt_o) + SW'(dty_cnt_o);

  AST_SUM_IS_N: assert property (@(posedge clk_i) disable iff (!rst_ni)
    total == SW'(N)); // R12

  AST_NEVER_UNSAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unsafe_o); // R11

  AST_RD_HIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_type_i == 3'd0) |=>
      ($stable(inv_cnt_o) && $stable(exc_cnt_o) && $stable(shr_cnt_o) && $stable(dty_cnt_o))); // R2

  AST_REJECT_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($stable(inv_cnt_o) && $stable(exc_cnt_o) && $stable(shr_cnt_o) && $stable(dty_cnt_o))); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_valid_i |=> !illegal_o); // R10

  AST_WR_MISS_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_type_i == 3'd3 && inv_cnt_o != '0) |=>
      (dty_cnt_o == CW'(1) && exc_cnt_o == '0 && shr_cnt_o == '0)); // R8

  AST_BAD_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_type_i == 3'd4 && victim_i == 2'd3) |=> illegal_o); // R9
endmodule

bind coh_pop_monitor coh_pop_monitor_chk #(.N(N), .CW(CW)) u_chk (.*);

// File: tb/coh_pop_monitor_bench.sv
module coh_pop_monitor_bench;
  localparam int N  = 4;
  localparam int CW = $clog2(N + 1);

  typedef struct {
    int    i, e, s, d;
    bit    ill;
    string req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_valid = 1'b0;
  logic [2:0]    ev_type = '0;
  logic [1:0]    victim = '0;
  logic [CW-1:0] inv_c, exc_c, shr_c, dty_c;
  logic          illegal, unsafe;

  int   n_chk = 0, n_fail = 0;
  int   mi = N, me = 0, ms = 0, md = 0;
  exp_t q[$];
  bit   done = 1'b0;

  always #5 clk = ~clk;

  coh_pop_monitor #(.N(N)) u_coh_pop_monitor (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_valid), .ev_type_i(ev_type),
    .victim_i(victim), .inv_cnt_o(inv_c), .exc_cnt_o(exc_c), .shr_cnt_o(shr_c),
    .dty_cnt_o(dty_c), .illegal_o(illegal), .unsafe_o(unsafe)
  );

  task automatic check(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // reference model built from the requirement text
  task automatic drive(input bit v, input int t, input int vic, input string req);
    exp_t x;
    bit   bad = 1'b0;
    @(negedge clk);
    ev_valid = v;
    ev_type  = 3'(t);
    victim   = 2'(vic);
    if (v) begin
      case (t)
        0: bad = (me + ms + md) == 0;
        1: if (mi == 0) bad = 1;
           else if (me + ms + md == 0) begin mi--; me++; end
           else if (md > 0) begin mi--; md--; ms += 2; end
           else begin mi--; ms = ms + me + 1; me = 0; end
        2: if (md > 0) ;
           else if (me > 0) begin me--; md++; end
           else if (ms > 0) begin mi = mi + ms - 1; ms = 0; md++; end
           else bad = 1;
        3: if (mi == 0) bad = 1;
           else begin mi = N - 1; me = 0; ms = 0; md = 1; end
        4: case (vic)
             0: if (md > 0) begin md--; mi++; end else bad = 1;
             1: if (ms > 0) begin ms--; mi++; end else bad = 1;
             2: if (me > 0) begin me--; mi++; end else bad = 1;
             default: bad = 1;
           endcase
        default: bad = 1;
      endcase
    end
    x.i = mi; x.e = me; x.s = ms; x.d = md; x.ill = bad; x.req = req;
    q.push_back(x);
  endtask

  initial begin : monitor
    exp_t x;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) check(unsafe == 1'b0, "R11", $sformatf("unsafe act=%0b exp=0", unsafe));
      if (q.size() > 0) begin
        x = q.pop_front();
        check(int'(inv_c) == x.i && int'(exc_c) == x.e && int'(shr_c) == x.s && int'(dty_c) == x.d,
              x.req, $sformatf("counts act=%0d/%0d/%0d/%0d exp=%0d/%0d/%0d/%0d",
              inv_c, exc_c, shr_c, dty_c, x.i, x.e, x.s, x.d));
        check(illegal == x.ill, x.req, $sformatf("illegal act=%0b exp=%0b", illegal, x.ill));
        check(int'(inv_c) + int'(exc_c) + int'(shr_c) + int'(dty_c) == N, "R12",
              $sformatf("sum act=%0d exp=%0d", int'(inv_c) + int'(exc_c) + int'(shr_c) + int'(dty_c), N));
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    #23;
    check(inv_c == CW'(N) && exc_c == 0 && shr_c == 0 && dty_c == 0 && !illegal && !unsafe,
          "R1", $sformatf("reset act=%0d/%0d/%0d/%0d exp=%0d/0/0/0", inv_c, exc_c, shr_c, dty_c, N));
    rst_n = 1'b1;
    drive(1, 0, 0, "R2");   // read hit with no copy: rejected
    drive(1, 2, 0, "R10");  // write hit with no copy
    drive(1, 4, 1, "R10");  // replace absent shared
    drive(1, 1, 0, "R3");   // I->E
    drive(1, 0, 0, "R2");
    drive(0, 3, 0, "R10");  // idle
    drive(1, 1, 0, "R5");   // exclusive present
    drive(1, 1, 0, "R5");
    drive(1, 2, 0, "R7");   // shared-only write hit
    drive(1, 2, 0, "R6");   // dirty: no change
    drive(1, 1, 0, "R4");   // dirty supplies
    drive(1, 1, 0, "R5");
    drive(1, 1, 0, "R10");  // invalid drained
    drive(1, 3, 0, "R10");  // write miss without invalid
    drive(1, 4, 1, "R9");
    drive(1, 3, 0, "R8");
    drive(1, 4, 0, "R9");
    drive(1, 1, 0, "R3");
    drive(1, 2, 0, "R6");   // exclusive -> dirty
    drive(1, 4, 3, "R9");   // reserved victim
    drive(1, 6, 0, "R10");  // reserved event
    drive(1, 1, 0, "R4");
    drive(1, 4, 2, "R9");   // no exclusive left
    drive(1, 4, 1, "R9");
    for (int k = 0; k < 600; k++)
      drive(1'($urandom_range(0, 7) != 0), $urandom_range(0, 5), $urandom_range(0, 3), "R10");
    drive(0, 0, 0, "R10");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule